// File: doc/BRIEF.md
# SPI Serial EEPROM Target with Layered Write Protection

This block is the target side of a serial EEPROM on an SPI bus (mode 0). A transaction opens when chip select falls. The first byte is an opcode. Array commands then take three address bytes, most significant first. Data bytes follow, and they are either streamed out of an internal byte array or collected for a page write. The array depth and page size are parameters, so a simulation can use a small array in place of the full 512 KiB part, which decodes 19 address bits.

Every change to stored state passes a series of gates before it is committed. The write-enable latch is checked first. The block-protection code is checked next. The external write-protect pin is checked last, and only when the status register enables it. Commits happen only when chip select rises on a byte boundary. After a commit the block reports busy for a fixed number of clock cycles and then drops the write-enable latch.

A second group of commands manages a one-byte partition configuration register. These commands have their own enable latch, and a freeze bit can lock the configuration for good. The bus pins are oversampled by the system clock.

Top module: `spi_eeprom_target`

## Requirements
- R1: The first byte after chip select falls is the opcode. Read (0x03) and write (0x02) take three address bytes, most significant first, and only the low ADDR_W address bits are used. MOSI is sampled on the rising SCK edge and MISO changes after the falling edge. A read's first data bit is valid before the first rising edge of the data byte.
- R2: The write-enable latch is status byte 0 bit 1. It is set only by opcode 0x06 and cleared by opcode 0x04. Each of these takes effect when chip select rises.
- R3: An array write (0x02) or a status write (0x01) is discarded unless the write-enable latch is set. It is also discarded if chip select rises in the middle of a byte. An accepted write sets status byte 0 bit 0 (busy) for BUSY_CYCLES clocks. The write-enable latch clears when that window ends.
- R4: The protection code in status byte 0 bits 3:2 selects the protected range. 00 protects nothing, 01 protects the top quarter of the array, 10 protects the top half, and 11 protects all of it. A data byte aimed at a protected address is dropped.
- R5: Status byte 0 bit 7 enables the active-low write-protect pin. When this bit is 1 and the pin is low, status writes are discarded, and in enhanced mode array writes are discarded as well. When the bit is 0, the pin has no effect.
- R6: Status byte 1 bit 7 holds the protection mode. Enhanced mode is 1, which is the reset value, and legacy mode is 0. The mode bit is written from bit 7 of the second data byte of a status write. In legacy mode the pin does not block array writes.
- R7: While busy, every opcode other than read-status (0x05) is ignored. A read returns zeros while busy.
- R8: A read increments its address after each byte and wraps from the last location to 0. Read-status returns status byte 0, then status byte 1, and repeats that pair for as long as chip select stays low.
- R9: The data bytes of a page write wrap within an aligned block of PAGE bytes. Locations outside that block are not touched.
- R10: Opcode 0x07 sets the partition enable latch, status byte 1 bit 4. The following commands are rejected while this latch is clear: partition write (0xB1, one data byte), freeze (0xC1) and boundary lock (0xB3, which sets status byte 1 bit 3). Each of these commands clears the latch when it completes. Opcode 0xB2 reads back the partition register.
- R11: Status byte 1 bit 5 is the freeze bit. Only an enabled freeze command can set it, and nothing clears it. Once it is set, partition writes, boundary lock and changes to the mode bit have no effect.
- R12: After reset, status byte 0 reads 0x00, status byte 1 reads 0x80 and the partition register reads 0x00. While chip select is high, the MISO enable output is 0 and MISO is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the SPI pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | Serial clock |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data into the block |
| spi_miso | output | 1 | Serial data out of the block |
| spi_miso_oe | output | 1 | MISO drive enable, high only while the block is selected |
| wp_n | input | 1 | Active-low write-protect pin |

## Verification
The protection layers are the riskiest logic, so the bench walks a vector table through all four protection codes at addresses on both sides of each range boundary. A design with a wrong range decode would store a byte where the prior value should remain. Chip select is raised mid-byte, and a design that commits anyway would show a busy window or a changed byte. The bench tests commands issued during the busy window. It checks address wrap on a read at the top of the array and on a page write near the end of a page, where a design without wrap would spill into the next page. The bench also checks the pin in both protection modes and the partition latch and freeze sequence. A design that left the latch set, or let a frozen register change, would read back the wrong status or the wrong partition value.

// File: rtl/eep_pkg.sv
package eep_pkg;
    // opcode values, shared by the decoder and any model of the host
    localparam logic [7:0] OP_WREN  = 8'h06;
    localparam logic [7:0] OP_WRDI  = 8'h04;
    localparam logic [7:0] OP_RDSR  = 8'h05;
    localparam logic [7:0] OP_WRSR  = 8'h01;
    localparam logic [7:0] OP_READ  = 8'h03;
    localparam logic [7:0] OP_WRITE = 8'h02;
    localparam logic [7:0] OP_PEN   = 8'h07;
    localparam logic [7:0] OP_PWR   = 8'hB1;
    localparam logic [7:0] OP_PRD   = 8'hB2;
    localparam logic [7:0] OP_FRZ   = 8'hC1;
    localparam logic [7:0] OP_BND   = 8'hB3;

    localparam int ADDR_BYTES = 3;

    typedef enum logic [1:0] {PH_CMD, PH_ADDR, PH_DATA, PH_SKIP} phase_e;
    typedef enum logic [1:0] {TX_NONE, TX_STAT, TX_MEM, TX_PART} txsrc_e;
endpackage

// File: rtl/eep_spi_phy.sv
module eep_spi_phy (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sck,
    input  logic       cs_n,
    input  logic       mosi,
    input  logic [7:0] tx_byte,
    output logic       byte_done,
    output logic [7:0] rx_byte,
    output logic       cs_rise,
    output logic       aligned,
    output logic       miso,
    output logic       miso_oe
);
    typedef struct packed {
        logic [2:0] sck3;
        logic [2:0] cs3;
        logic [1:0] mo2;
        logic [7:0] rx;
        logic [2:0] bcnt;
        logic [7:0] txsh;
        logic       pend;
        logic       miso;
        logic       oe;
    } phy_t;

    phy_t q, d;
    logic sel, rise, fall;

    assign sel       = ~q.cs3[1];
    assign rise      = q.sck3[1] & ~q.sck3[2];
    assign fall      = ~q.sck3[1] & q.sck3[2];
    assign cs_rise   = q.cs3[1] & ~q.cs3[2];
    assign aligned   = (q.bcnt == 3'd0);
    assign byte_done = sel & rise & (q.bcnt == 3'd7);
    assign rx_byte   = {q.rx[6:0], q.mo2[1]};
    assign miso      = q.miso;
    assign miso_oe   = q.oe;

    always_comb begin
        d      = q;
        d.sck3 = {q.sck3[1:0], sck};
        d.cs3  = {q.cs3[1:0], cs_n};
        d.mo2  = {q.mo2[0], mosi};
        d.oe   = sel;
        if (!sel) begin
            d.bcnt = 3'd0;
            d.pend = 1'b0;
            d.miso = 1'b0;
            d.txsh = 8'h00;
        end else begin
            if (rise) begin
                d.rx   = {q.rx[6:0], q.mo2[1]};
                d.bcnt = q.bcnt + 3'd1;
                if (q.bcnt == 3'd7) d.pend = 1'b1;
            end
            if (fall) begin
                if (q.pend) begin
                    d.miso = tx_byte[7];
                    d.txsh = {tx_byte[6:0], 1'b0};
                    d.pend = 1'b0;
                end else begin
                    d.miso = q.txsh[7];
                    d.txsh = {q.txsh[6:0], 1'b0};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            q.cs3 <= 3'b111;
        end else begin
            q <= d;
        end
    end

    AST_MISO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !miso_oe |-> !miso) else $error("miso driven while deselected"); // R12
endmodule

// File: rtl/eep_guard.sv
module eep_guard #(
    parameter int ADDR_W = 10
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        bp,
    output logic              hit
);
    localparam int TOP = ADDR_W - 1;

    always_comb begin
        unique case (bp)
            2'b00: hit = 1'b0;
            2'b01: hit = (addr[TOP -: 2] == 2'b11);
            2'b10: hit = addr[TOP];
            default: hit = 1'b1;
        endcase
    end
endmodule

// File: rtl/eep_array.sv
module eep_array #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [7:0]        rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/spi_eeprom_target.sv
module spi_eeprom_target #(
    parameter int ADDR_W      = 10,
    parameter int PAGE        = 16,
    parameter int BUSY_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_sck,
    input  logic spi_cs_n,
    input  logic spi_mosi,
    output logic spi_miso,
    output logic spi_miso_oe,
    input  logic wp_n
);
    import eep_pkg::*;

    localparam int PG_W  = $clog2(PAGE);
    localparam int CNT_W = $clog2(BUSY_CYCLES);

    typedef struct packed {
        phase_e                 ph;
        logic [7:0]             cmd;
        logic [1:0]             acnt;
        logic [ADDR_W-1:0]      addr;
        logic [1:0]             sr_cnt;
        logic                   sr_wpen;
        logic [1:0]             sr_bp;
        logic                   sr_mode;
        logic [7:0]             pnew;
        logic                   pnew_v;
        logic                   wpen;
        logic [1:0]             bp;
        logic                   wel;
        logic                   busy;
        logic                   arr;
        logic                   wpm;
        logic                   frz;
        logic                   prel;
        logic                   pabp;
        logic [7:0]             part;
        logic [PAGE-1:0][7:0]   pbuf;
        logic [PAGE-1:0]        pmask;
        logic [PG_W-1:0]        widx;
        logic [ADDR_W-1:0]      pbase;
        logic [CNT_W-1:0]       bcnt;
        logic [PG_W:0]          walk;
        txsrc_e                 txs;
        logic                   sidx;
        logic [ADDR_W-1:0]      rptr;
    } st_t;

    st_t q, d;

    logic              byte_done, cs_rise, aligned;
    logic [7:0]        rx_byte, tx_byte, rdata;
    logic [7:0]        stat0, stat1;
    logic              pin_block, walk_on, prot_hit, mem_we;
    logic [ADDR_W-1:0] mem_waddr, new_addr;

    eep_spi_phy u_phy (
        .clk       (clk),
        .rst_n     (rst_n),
        .sck       (spi_sck),
        .cs_n      (spi_cs_n),
        .mosi      (spi_mosi),
        .tx_byte   (tx_byte),
        .byte_done (byte_done),
        .rx_byte   (rx_byte),
        .cs_rise   (cs_rise),
        .aligned   (aligned),
        .miso      (spi_miso),
        .miso_oe   (spi_miso_oe)
    );

    // commit walk: one page slot per clock inside the busy window
    assign walk_on   = q.busy & q.arr & (q.walk < (PG_W+1)'(PAGE));
    assign mem_waddr = {q.pbase[ADDR_W-1:PG_W], q.walk[PG_W-1:0]};

    eep_guard #(.ADDR_W(ADDR_W)) u_guard (
        .addr (mem_waddr),
        .bp   (q.bp),
        .hit  (prot_hit)
    );

    assign mem_we = walk_on & q.pmask[q.walk[PG_W-1:0]] & ~prot_hit;

    eep_array #(.ADDR_W(ADDR_W)) u_array (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (q.pbuf[q.walk[PG_W-1:0]]),
        .raddr (q.rptr),
        .rdata (rdata)
    );

    assign stat0     = {q.wpen, 3'b000, q.bp, q.wel, q.busy};
    assign stat1     = {q.wpm, 1'b0, q.frz, q.prel, q.pabp, 3'b000};
    assign pin_block = q.wpen & ~wp_n;
    assign new_addr  = ADDR_W'({q.addr, rx_byte});

    always_comb begin
        unique case (q.txs)
            TX_STAT: tx_byte = q.sidx ? stat1 : stat0;
            TX_MEM:  tx_byte = rdata;
            TX_PART: tx_byte = q.part;
            default: tx_byte = 8'h00;
        endcase
    end

    always_comb begin
        d = q;

        // busy window and commit walk
        if (q.busy) begin
            d.bcnt = q.bcnt + CNT_W'(1);
            if (walk_on) d.walk = q.walk + (PG_W+1)'(1);
            if (q.bcnt == CNT_W'(BUSY_CYCLES - 1)) begin
                d.busy = 1'b0;
                d.wel  = 1'b0;
                d.arr  = 1'b0;
            end
        end

        // byte framing
        if (byte_done) begin
            unique case (q.ph)
                PH_CMD: begin
                    d.cmd    = rx_byte;
                    d.sr_cnt = 2'd0;
                    d.pnew_v = 1'b0;
                    d.sidx   = 1'b0;
                    d.txs    = TX_NONE;
                    d.acnt   = 2'd0;
                    if (q.busy && rx_byte != OP_RDSR) begin
                        d.ph = PH_SKIP;
                    end else if (rx_byte == OP_READ || rx_byte == OP_WRITE) begin
                        d.ph = PH_ADDR;
                    end else begin
                        d.ph = PH_DATA;
                        if (rx_byte == OP_RDSR) d.txs = TX_STAT;
                        if (rx_byte == OP_PRD)  d.txs = TX_PART;
                    end
                end
                PH_ADDR: begin
                    d.addr = new_addr;
                    d.acnt = q.acnt + 2'd1;
                    if (q.acnt == 2'(ADDR_BYTES - 1)) begin
                        d.ph    = PH_DATA;
                        d.pbase = new_addr;
                        d.widx  = new_addr[PG_W-1:0];
                        d.pmask = '0;
                        d.rptr  = new_addr;
                        if (q.cmd == OP_READ) d.txs = TX_MEM;
                    end
                end
                PH_DATA: begin
                    unique case (q.cmd)
                        OP_READ: d.rptr = q.rptr + ADDR_W'(1);
                        OP_RDSR: d.sidx = ~q.sidx;
                        OP_WRITE: begin
                            d.pbuf[q.widx]  = rx_byte;
                            d.pmask[q.widx] = 1'b1;
                            d.widx          = q.widx + PG_W'(1);
                        end
                        OP_WRSR: begin
                            if (q.sr_cnt == 2'd0) begin
                                d.sr_wpen = rx_byte[7];
                                d.sr_bp   = rx_byte[3:2];
                            end else if (q.sr_cnt == 2'd1) begin
                                d.sr_mode = rx_byte[7];
                            end
                            if (q.sr_cnt != 2'd2) d.sr_cnt = q.sr_cnt + 2'd1;
                        end
                        OP_PWR: begin
                            if (!q.pnew_v) begin
                                d.pnew   = rx_byte;
                                d.pnew_v = 1'b1;
                            end
                        end
                        default: ;
                    endcase
                end
                default: ;
            endcase
        end

        // transaction end: commit only on a byte boundary and when idle
        if (cs_rise) begin
            d.ph  = PH_CMD;
            d.txs = TX_NONE;
            if (aligned && q.ph == PH_DATA && !q.busy) begin
                unique case (q.cmd)
                    OP_WREN: d.wel  = 1'b1;
                    OP_WRDI: d.wel  = 1'b0;
                    OP_PEN:  d.prel = 1'b1;
                    OP_WRITE: begin
                        if (q.wel && (|q.pmask) && !(pin_block && q.wpm)) begin
                            d.busy = 1'b1;
                            d.arr  = 1'b1;
                            d.bcnt = '0;
                            d.walk = '0;
                        end
                    end
                    OP_WRSR: begin
                        if (q.wel && q.sr_cnt != 2'd0 && !pin_block) begin
                            d.wpen = q.sr_wpen;
                            d.bp   = q.sr_bp;
                            if (q.sr_cnt == 2'd2 && !q.frz) d.wpm = q.sr_mode;
                            d.busy = 1'b1;
                            d.arr  = 1'b0;
                            d.bcnt = '0;
                            d.walk = '0;
                        end
                    end
                    OP_PWR: begin
                        if (q.prel) begin
                            if (!q.frz && q.pnew_v) d.part = q.pnew;
                            d.prel = 1'b0;
                        end
                    end
                    OP_FRZ: begin
                        if (q.prel) begin
                            d.frz  = 1'b1;
                            d.prel = 1'b0;
                        end
                    end
                    OP_BND: begin
                        if (q.prel) begin
                            if (!q.frz) d.pabp = 1'b1;
                            d.prel = 1'b0;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            q.wpm <= 1'b1;
        end else begin
            q <= d;
        end
    end

    AST_WEL_SET_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.wel) |-> $past(cs_rise && q.cmd == OP_WREN)) else $error("wel set without enable"); // R2
    AST_BUSY_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.busy) |-> $past(q.wel)) else $error("write started without wel"); // R3
    AST_WEL_DROPS_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.busy) |-> !q.wel) else $error("wel kept after write cycle"); // R3
    AST_WEL_HELD_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        q.busy && $past(q.busy) |-> q.wel) else $error("command acted while busy"); // R7
    AST_FREEZE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(q.frz) |-> q.frz) else $error("freeze bit cleared"); // R11
    AST_PART_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        q.frz && $past(q.frz) |-> $stable(q.part) && $stable(q.wpm)) else $error("frozen state changed"); // R11
endmodule

// File: tb/spi_eeprom_target_bench.sv
module spi_eeprom_target_bench;
    localparam int HALF = 5;
    localparam int BUSY = 1200;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic spi_sck = 1'b0;
    logic spi_cs_n = 1'b1;
    logic spi_mosi = 1'b0;
    logic wp_n = 1'b1;
    logic spi_miso, spi_miso_oe;

    int checks = 0;
    int errors = 0;

    logic [7:0] txb [16];
    logic [7:0] rxb [16];

    always #10 clk = ~clk;

    spi_eeprom_target #(.ADDR_W(10), .PAGE(16), .BUSY_CYCLES(BUSY)) u_spi_eeprom_target (
        .clk         (clk),
        .rst_n       (rst_n),
        .spi_sck     (spi_sck),
        .spi_cs_n    (spi_cs_n),
        .spi_mosi    (spi_mosi),
        .spi_miso    (spi_miso),
        .spi_miso_oe (spi_miso_oe),
        .wp_n        (wp_n)
    );

    // vector: {protect code, address, data written, value read back}
    localparam logic [39:0] VEC [8] = '{
        {8'h00, 16'h03FF, 8'h11, 8'h11},
        {8'h01, 16'h03FF, 8'h22, 8'h11},
        {8'h01, 16'h02FF, 8'h33, 8'h33},
        {8'h02, 16'h02FF, 8'h44, 8'h33},
        {8'h02, 16'h01FF, 8'h55, 8'h55},
        {8'h03, 16'h0000, 8'h66, 8'hEE},
        {8'h00, 16'h0000, 8'h77, 8'h77},
        {8'h01, 16'h0300, 8'h88, 8'hEE}
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic spi(input int n, input int lastbits);
        spi_cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int b = 0; b < n; b++) begin
            for (int i = 7; i >= 0; i--) begin
                if (b == n - 1 && (7 - i) >= lastbits) break;
                spi_mosi = txb[b][i];
                repeat (HALF) @(negedge clk);
                rxb[b][i] = spi_miso;
                spi_sck = 1'b1;
                repeat (HALF) @(negedge clk);
                spi_sck = 1'b0;
            end
        end
        repeat (HALF) @(negedge clk);
        spi_cs_n = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic op1(input logic [7:0] op);
        txb[0] = op;
        spi(1, 8);
    endtask

    task automatic rdsr(output logic [7:0] s0, output logic [7:0] s1);
        txb[0] = 8'h05; txb[1] = 8'h00; txb[2] = 8'h00;
        spi(3, 8);
        s0 = rxb[1];
        s1 = rxb[2];
    endtask

    task automatic wrsr(input logic [7:0] b0, input logic [7:0] b1, input int n);
        txb[0] = 8'h01; txb[1] = b0; txb[2] = b1;
        spi(1 + n, 8);
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] v);
        txb[0] = 8'h02; txb[1] = 8'h00; txb[2] = a[15:8]; txb[3] = a[7:0]; txb[4] = v;
        spi(5, 8);
    endtask

    task automatic rd(input logic [15:0] a, input int n);
        txb[0] = 8'h03; txb[1] = 8'h00; txb[2] = a[15:8]; txb[3] = a[7:0];
        for (int k = 0; k < n; k++) txb[4 + k] = 8'h00;
        spi(4 + n, 8);
    endtask

    task automatic settle();
        repeat (BUSY + 20) @(negedge clk);
    endtask

    task automatic prd(output logic [7:0] v);
        txb[0] = 8'hB2; txb[1] = 8'h00;
        spi(2, 8);
        v = rxb[1];
    endtask

    logic [7:0] s0, s1, pv;
    logic done = 1'b0;

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R12 reset state
        chk("R12 miso_oe idle", {7'd0, spi_miso_oe}, 8'h00);
        chk("R12 miso idle", {7'd0, spi_miso}, 8'h00);
        rdsr(s0, s1);
        chk("R12 status0 reset", s0, 8'h00);
        chk("R12 status1 reset", s1, 8'h80);
        prd(pv);
        chk("R12 partition reset", pv, 8'h00);

        // R2 enable latch set and clear
        op1(8'h06); rdsr(s0, s1);
        chk("R2 wel set", s0, 8'h02);
        op1(8'h04); rdsr(s0, s1);
        chk("R2 wel cleared", s0, 8'h00);

        // prefill
        op1(8'h06); wr(16'h0000, 8'hEE); settle();
        op1(8'h06); wr(16'h0300, 8'hEE); settle();
        op1(8'h06); wr(16'h0010, 8'h5A); settle();
        op1(8'h06); wr(16'h0030, 8'h5A); settle();

        // R4 / R1 vector walk over protection codes
        for (int v = 0; v < 8; v++) begin
            op1(8'h06); wrsr({4'h0, VEC[v][33:32], 2'b00}, 8'h00, 1); settle();
            op1(8'h06); wr(VEC[v][31:16], VEC[v][15:8]); settle();
            rd(VEC[v][31:16], 1);
            chk($sformatf("R4 R1 vector %0d", v), rxb[4], VEC[v][7:0]);
        end
        op1(8'h06); wrsr(8'h00, 8'h00, 1); settle();

        // R8 read wrap and status alternation
        rd(16'h03FF, 2);
        chk("R8 read at top", rxb[4], 8'h11);
        chk("R8 read wraps to 0", rxb[5], 8'h77);
        txb[0] = 8'h05; txb[1] = 0; txb[2] = 0; txb[3] = 0; txb[4] = 0;
        spi(5, 8);
        chk("R8 status pair 3rd", rxb[3], 8'h00);
        chk("R8 status pair 4th", rxb[4], 8'h80);

        // R3 write without enable
        wr(16'h0010, 8'hAB);
        rdsr(s0, s1);
        chk("R3 no wel no busy", s0, 8'h00);
        rd(16'h0010, 1);
        chk("R3 no wel data kept", rxb[4], 8'h5A);

        // R3 chip select raised mid-byte
        op1(8'h06);
        txb[0] = 8'h02; txb[1] = 8'h00; txb[2] = 8'h00; txb[3] = 8'h10; txb[4] = 8'hAB;
        spi(5, 4);
        rdsr(s0, s1);
        chk("R3 partial byte discarded", s0, 8'h02);
        rd(16'h0010, 1);
        chk("R3 partial data kept", rxb[4], 8'h5A);
        op1(8'h04);

        // R3 / R7 busy window
        op1(8'h06); wr(16'h0030, 8'hC3);
        txb[0] = 8'h05; txb[1] = 8'h00;
        spi(2, 8);
        chk("R3 busy and wel", rxb[1], 8'h03);
        rd(16'h0010, 1);
        chk("R7 read ignored while busy", rxb[4], 8'h00);
        op1(8'h07);
        settle();
        rdsr(s0, s1);
        chk("R3 wel clears after busy", s0, 8'h00);
        chk("R7 partition enable ignored while busy", s1, 8'h80);
        rd(16'h0030, 1);
        chk("R3 committed data", rxb[4], 8'hC3);

        // R9 page wrap
        op1(8'h06);
        txb[0] = 8'h02; txb[1] = 8'h00; txb[2] = 8'h00; txb[3] = 8'h2E;
        txb[4] = 8'h01; txb[5] = 8'h02; txb[6] = 8'h03; txb[7] = 8'h04;
        spi(8, 8); settle();
        rd(16'h002E, 2);
        chk("R9 page tail 0", rxb[4], 8'h01);
        chk("R9 page tail 1", rxb[5], 8'h02);
        rd(16'h0020, 2);
        chk("R9 wrapped 0", rxb[4], 8'h03);
        chk("R9 wrapped 1", rxb[5], 8'h04);
        rd(16'h0030, 1);
        chk("R9 next page untouched", rxb[4], 8'hC3);

        // R5 write-protect pin, enhanced mode
        op1(8'h06); wrsr(8'h80, 8'h00, 1); settle();
        wp_n = 1'b0;
        op1(8'h06); wr(16'h0010, 8'h99);
        rdsr(s0, s1);
        chk("R5 array write blocked by pin", s0, 8'h82);
        rd(16'h0010, 1);
        chk("R5 array data kept", rxb[4], 8'h5A);
        wrsr(8'h00, 8'h00, 1);
        rdsr(s0, s1);
        chk("R5 status write blocked by pin", s0, 8'h82);

        // R6 legacy mode lets array writes pass the pin
        wp_n = 1'b1;
        wrsr(8'h80, 8'h00, 2); settle();
        rdsr(s0, s1);
        chk("R6 legacy mode selected", s1, 8'h00);
        wp_n = 1'b0;
        op1(8'h06); wr(16'h0010, 8'h99); settle();
        rd(16'h0010, 1);
        chk("R6 legacy array write", rxb[4], 8'h99);
        op1(8'h06); wrsr(8'h00, 8'h00, 1);
        rdsr(s0, s1);
        chk("R5 legacy status still blocked", s0, 8'h82);
        op1(8'h04);
        wp_n = 1'b1;
        op1(8'h06); wrsr(8'h00, 8'h80, 2); settle();
        rdsr(s0, s1);
        chk("R6 enhanced restored", s1, 8'h80);
        chk("R5 pin disabled", s0, 8'h00);

        // R10 partition latch
        txb[0] = 8'hB1; txb[1] = 8'h5C; spi(2, 8);
        prd(pv);
        chk("R10 write rejected without latch", pv, 8'h00);
        op1(8'h07); rdsr(s0, s1);
        chk("R10 latch set", s1, 8'h90);
        txb[0] = 8'hB1; txb[1] = 8'h5C; spi(2, 8);
        prd(pv);
        chk("R10 partition written", pv, 8'h5C);
        rdsr(s0, s1);
        chk("R10 latch cleared after write", s1, 8'h80);
        op1(8'hB3); rdsr(s0, s1);
        chk("R10 boundary lock rejected", s1, 8'h80);
        op1(8'h07); op1(8'hB3); rdsr(s0, s1);
        chk("R10 boundary lock set", s1, 8'h88);

        // R11 freeze
        op1(8'hC1); rdsr(s0, s1);
        chk("R11 freeze needs latch", s1, 8'h88);
        op1(8'h07); op1(8'hC1); rdsr(s0, s1);
        chk("R11 frozen", s1, 8'hA8);
        op1(8'h07);
        txb[0] = 8'hB1; txb[1] = 8'h11; spi(2, 8);
        prd(pv);
        chk("R11 partition locked", pv, 8'h5C);
        op1(8'h06); wrsr(8'h00, 8'h00, 2); settle();
        rdsr(s0, s1);
        chk("R11 mode bit locked", s1, 8'hA8);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule